// File: doc/BRIEF.md
# Arrow Key Hold Tracker

This block sits behind a keyboard serial receiver. It takes the received scan-code bytes one at a time, each marked by a single-cycle valid strobe. A small parser walks through the multi-byte press and release sequences of the four cursor-arrow keys. For each arrow key it keeps one flag, and that flag is high for as long as the key is held down. Any number of the four keys can be held at the same time, and each flag is updated only by its own key's sequences.

The parser has four named states. `ST_IDLE` waits for a sequence to start. `ST_EXT` means the extended prefix 0xE0 has arrived. `ST_EXT_REL` means 0xE0 followed by the release marker 0xF0 has arrived. `ST_REL` means a bare 0xF0 has arrived.

The transitions, taken only on a strobed byte, are as follows.
- From `ST_IDLE`, 0xE0 goes to `ST_EXT`, 0xF0 goes to `ST_REL`, and any other byte stays in `ST_IDLE`.
- From `ST_EXT`, 0xF0 goes to `ST_EXT_REL`. Any other byte returns to `ST_IDLE`; if that byte is an arrow code, it also sets the key's flag.
- From `ST_EXT_REL`, any byte returns to `ST_IDLE`; if that byte is an arrow code, it also clears the key's flag.
- From `ST_REL`, any byte returns to `ST_IDLE` and has no other effect.

The four flags drive indicator segments directly.

Top module: `arrow_key_tracker`

## Requirements
- R1: A synchronous active-high `rst` sampled at a rising clock edge clears all four `key_held` bits at that edge. It also drops any partly received sequence, so bytes after reset start a new sequence.
- R2: The strobed sequences E0 75, E0 72, E0 6B and E0 74 set `key_held` bit 0 (up), bit 1 (down), bit 2 (left) and bit 3 (right) respectively. The bit is set at the rising edge that samples the strobe of the final byte.
- R3: The strobed sequence E0 F0 followed by one of the four arrow codes clears the matching `key_held` bit, at the edge that samples the final byte.
- R4: Each sequence changes at most its own key's bit. All other bits keep their values, so several keys can be shown held at once.
- R5: A non-extended release sequence (F0 followed by any byte) is consumed and changes no flag. The byte after F0 is not taken as the start of a new sequence, even when it is 0xE0.
- R6: A byte that a partial sequence does not expect ends that sequence and changes no flag. This covers 0xE0 after E0, a non-arrow byte after E0, and any non-arrow byte after E0 F0. Parsing then restarts from idle with the next byte.
- R7: Bytes of other keys change no flag. This covers extended non-arrow codes such as E0 70, and an arrow code value received without the E0 prefix.
- R8: Changes on `rx_byte` while `rx_valid` is low have no effect on the flags or on the parse.
- R9: A repeated press sequence for a key that is already held leaves its bit set. A release sequence for a key that is not held leaves its bit clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_byte | input | 8 | Received byte from the serial receiver |
| rx_valid | input | 1 | Single-cycle strobe marking `rx_byte` as a new byte |
| key_held | output | 4 | Held flags: bit 0 up, bit 1 down, bit 2 left, bit 3 right |

## Verification
A wrong parser state has no immediate effect at the ports. It shows up only when a later strobed byte finishes, or fails to finish, a sequence. The result is a flag that sets, clears or stays put wrongly at the edge after that byte's strobe. Because of this, the bench drives sequences whose final byte gives a different flag result depending on the preceding state: F0 E0 72, E0 E0 72, E0 F0 E0 75, and reset in the middle of a sequence. The bench compares all four flags against its reference model on every cycle, so a wrong flag is reported within one clock of the strobe that should have changed it.

// File: rtl/arrow_pkg.sv
package arrow_pkg;
    localparam int BYTE_W    = 8;
    localparam int KEY_COUNT = 4;

    localparam logic [BYTE_W-1:0] PFX_EXT = 8'hE0;
    localparam logic [BYTE_W-1:0] PFX_REL = 8'hF0;

    // index 0 up, 1 down, 2 left, 3 right
    localparam logic [BYTE_W-1:0] ARROW_CODE [KEY_COUNT] = '{8'h75, 8'h72, 8'h6B, 8'h74};

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_EXT     = 2'd1,
        ST_EXT_REL = 2'd2,
        ST_REL     = 2'd3
    } seq_state_e;
endpackage

// File: rtl/arrow_code_match.sv
module arrow_code_match
    import arrow_pkg::*;
#(
    parameter int NKEYS = KEY_COUNT
) (
    input  logic [BYTE_W-1:0] code_in,
    output logic [NKEYS-1:0]  hit
);
    for (genvar k = 0; k < NKEYS; k++) begin : g_cmp
        assign hit[k] = (code_in == ARROW_CODE[k]);
    end
endmodule

// File: rtl/arrow_seq_parser.sv
module arrow_seq_parser
    import arrow_pkg::*;
#(
    parameter int NKEYS = KEY_COUNT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic [NKEYS-1:0]  code_hit,
    output seq_state_e        state,
    output logic [NKEYS-1:0]  set_req,
    output logic [NKEYS-1:0]  clr_req
);
    seq_state_e nxt;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    always_comb begin
        nxt     = state;
        set_req = '0;
        clr_req = '0;
        if (byte_valid) begin
            unique case (state)
                ST_IDLE: begin
                    if (byte_in == PFX_EXT)      nxt = ST_EXT;
                    else if (byte_in == PFX_REL) nxt = ST_REL;
                    else                         nxt = ST_IDLE;
                end
                ST_EXT: begin
                    if (byte_in == PFX_REL) begin
                        nxt = ST_EXT_REL;
                    end else begin
                        nxt     = ST_IDLE;
                        set_req = code_hit;
                    end
                end
                ST_EXT_REL: begin
                    nxt     = ST_IDLE;
                    clr_req = code_hit;
                end
                ST_REL: begin
                    nxt = ST_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/key_flag_bank.sv
module key_flag_bank #(
    parameter int NKEYS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NKEYS-1:0] set_req,
    input  logic [NKEYS-1:0] clr_req,
    output logic [NKEYS-1:0] held
);
    for (genvar k = 0; k < NKEYS; k++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)             held[k] <= 1'b0;
            else if (set_req[k]) held[k] <= 1'b1;
            else if (clr_req[k]) held[k] <= 1'b0;
        end
    end
endmodule

// File: rtl/arrow_key_tracker.sv
module arrow_key_tracker
    import arrow_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_valid,
    output logic [KEY_COUNT-1:0] key_held
);
    logic [KEY_COUNT-1:0] code_hit;
    logic [KEY_COUNT-1:0] set_req;
    logic [KEY_COUNT-1:0] clr_req;
    seq_state_e           cur_state;

    arrow_code_match #(.NKEYS(KEY_COUNT)) u_match (
        .code_in (rx_byte),
        .hit     (code_hit)
    );

    arrow_seq_parser #(.NKEYS(KEY_COUNT)) u_parser (
        .clk        (clk),
        .rst        (rst),
        .byte_valid (rx_valid),
        .byte_in    (rx_byte),
        .code_hit   (code_hit),
        .state      (cur_state),
        .set_req    (set_req),
        .clr_req    (clr_req)
    );

    key_flag_bank #(.NKEYS(KEY_COUNT)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_req (set_req),
        .clr_req (clr_req),
        .held    (key_held)
    );
endmodule

// File: rtl/arrow_key_tracker_chk.sv
module arrow_key_tracker_chk
    import arrow_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic [BYTE_W-1:0]    rx_byte,
    input logic                 rx_valid,
    input logic [KEY_COUNT-1:0] key_held,
    input seq_state_e           state
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (key_held == '0) && (state == ST_IDLE));

    a_r8_hold_without_strobe: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |=> $stable(key_held) && $stable(state));

    a_r4_one_bit_per_byte: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ($countones(key_held ^ $past(key_held)) <= 1));

    a_r5_plain_release_consumed: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && state == ST_REL) |=> $stable(key_held) && (state == ST_IDLE));

    a_r7_idle_other_byte_ignored: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && state == ST_IDLE && rx_byte != PFX_EXT && rx_byte != PFX_REL)
        |=> $stable(key_held) && (state == ST_IDLE));

    a_r6_double_prefix_drops: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && state == ST_EXT && rx_byte == PFX_EXT)
        |=> $stable(key_held) && (state == ST_IDLE));

    for (genvar k = 0; k < KEY_COUNT; k++) begin : g_key
        a_r2_make_sets: assert property (@(posedge clk) disable iff (rst)
            (rx_valid && state == ST_EXT && rx_byte == ARROW_CODE[k]) |=> key_held[k]);
        a_r3_break_clears: assert property (@(posedge clk) disable iff (rst)
            (rx_valid && state == ST_EXT_REL && rx_byte == ARROW_CODE[k]) |=> !key_held[k]);
    end
endmodule

bind arrow_key_tracker arrow_key_tracker_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .rx_byte  (rx_byte),
    .rx_valid (rx_valid),
    .key_held (key_held),
    .state    (cur_state)
);

// File: tb/arrow_key_tracker_bench.sv
`timescale 1ns/1ps
module arrow_key_tracker_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] rx_byte = 8'h00;
    logic       rx_valid = 1'b0;
    logic [3:0] key_held;

    int vectors = 0;
    int errors  = 0;
    bit started = 1'b0;
    bit done    = 1'b0;

    // reference model
    int         m_state = 0;
    logic [3:0] m_flags = 4'h0;

    arrow_key_tracker u_arrow_key_tracker (
        .clk      (clk),
        .rst      (rst),
        .rx_byte  (rx_byte),
        .rx_valid (rx_valid),
        .key_held (key_held)
    );

    always #5 clk = ~clk;

    function automatic int key_of(input logic [7:0] b);
        if (b == 8'h75) return 0;
        if (b == 8'h72) return 1;
        if (b == 8'h6B) return 2;
        if (b == 8'h74) return 3;
        return -1;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_state <= 0;
            m_flags <= 4'h0;
        end else if (rx_valid) begin
            int k;
            k = key_of(rx_byte);
            if (m_state == 0) begin
                if (rx_byte == 8'hE0)      m_state <= 1;
                else if (rx_byte == 8'hF0) m_state <= 3;
            end else if (m_state == 1) begin
                if (rx_byte == 8'hF0) m_state <= 2;
                else begin
                    m_state <= 0;
                    if (k >= 0) m_flags[k] <= 1'b1;
                end
            end else if (m_state == 2) begin
                m_state <= 0;
                if (k >= 0) m_flags[k] <= 1'b0;
            end else begin
                m_state <= 0;
            end
        end
    end

    always @(negedge clk) begin
        if (started && !done) begin
            vectors++;
            if (key_held !== m_flags) begin
                errors++;
                $display("FAIL model R4 t=%0t key_held actual=%b expected=%b", $time, key_held, m_flags);
            end
        end
    end

    task automatic check(input string tag, input logic [3:0] exp);
        vectors++;
        if (key_held !== exp) begin
            errors++;
            $display("FAIL %s key_held actual=%b expected=%b", tag, key_held, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        rx_byte  = b;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
        rx_byte  = 8'h5A;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        started = 1'b1;
        check("R1 after reset", 4'b0000);

        send(8'hE0); check("R2 prefix alone", 4'b0000);
        send(8'h75); check("R2 up make", 4'b0001);
        send(8'hE0); send(8'h6B); check("R2 R4 left make", 4'b0101);
        send(8'hE0); send(8'h74); check("R2 right make", 4'b1101);
        send(8'hE0); send(8'h72); check("R2 R4 down make", 4'b1111);
        send(8'hE0); send(8'hF0); check("R3 partial break", 4'b1111);
        send(8'h72); check("R3 R4 down break", 4'b1101);

        send(8'hF0); send(8'h75); check("R5 plain F0 75", 4'b1101);
        send(8'hF0); send(8'hE0); send(8'h72); check("R5 F0 E0 72", 4'b1101);

        send(8'hE0); send(8'hE0); send(8'h72); check("R6 E0 E0 72", 4'b1101);
        send(8'hE0); send(8'hF0); send(8'hE0); send(8'h75); check("R6 E0 F0 E0 75", 4'b1101);
        send(8'hE0); send(8'hF0); send(8'h12); check("R6 E0 F0 12", 4'b1101);
        send(8'hE0); send(8'h11); send(8'h72); check("R6 E0 11 72", 4'b1101);

        send(8'hE0); send(8'h70); check("R7 E0 70", 4'b1101);
        send(8'h72); check("R7 bare 72", 4'b1101);

        @(negedge clk); rx_byte = 8'hE0;
        @(negedge clk); rx_byte = 8'h72;
        @(negedge clk); rx_byte = 8'hF0;
        @(negedge clk); rx_byte = 8'h75;
        @(negedge clk); check("R8 unstrobed bytes", 4'b1101);
        send(8'hE0);
        @(negedge clk); rx_byte = 8'hF0;
        @(negedge clk);
        send(8'h75); check("R8 unstrobed F0 skipped", 4'b1101);

        send(8'hE0); send(8'h75); check("R9 repeat make", 4'b1101);
        send(8'hE0); send(8'hF0); send(8'h74); check("R3 right break", 4'b0101);
        send(8'hE0); send(8'hF0); send(8'h74); check("R9 break unheld", 4'b0101);
        send(8'hE0); send(8'hF0); send(8'h75);
        send(8'hE0); send(8'hF0); send(8'h6B); check("R3 all released", 4'b0000);

        send(8'hE0); send(8'h6B); check("R2 left again", 4'b0100);
        do_reset(); check("R1 reset clears held", 4'b0000);
        send(8'hE0); do_reset(); send(8'h75); check("R1 reset drops prefix", 4'b0000);
        send(8'hE0); send(8'hF0); do_reset();
        send(8'hE0); send(8'h72); check("R1 fresh after reset", 4'b0010);

        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule